// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer with APB Register Access

This block is a watchdog timer that sits on an APB slave port. Once software enables it, an internal down-counter runs from a reload value picked by a 4-bit range field. The reload value gives a period of 2^(BASE_SHIFT+range) clock cycles, and BASE_SHIFT defaults to 16. Software keeps the system alive by writing a fixed key to a restart register. Writes of any other value do nothing. If the counter reaches zero before a valid restart, the block reacts.

The response is set by a mode bit. In direct mode, every expiry drives a reset request pulse lasting PULSE_CYC cycles. In warning mode, the first expiry raises an interrupt. Software clears that interrupt by reading an end-of-interrupt register. If the interrupt is still pending at the following expiry, the reset pulse is issued. After an expiry the counter reloads and keeps running.

The enable bit is sticky, so only a block reset turns the watchdog off. A read-only register returns a fixed identification constant. The APB port never inserts wait states and never reports an error. The register interface is a plain APB handshake, and irq and rst_req are level control pins, so the block has no valid/ready stream.

Top module: `apb_watchdog`

## Requirements
- R1: After reset, irq and rst_req are 0, the control register reads 0 and the counter (offset 0x08) reads 0.
- R2: A read of offset 0x18 returns the VERSION parameter (default 0x3130332A).
- R3: Control offset 0x00 has bit 0 = enable and bit 1 = mode (0 direct reset, 1 interrupt first). Once enable is 1, writing 0 to bit 0 leaves it at 1, while bit 1 stays writable.
- R4: A write that takes enable from 0 to 1 loads the counter with 2^(BASE_SHIFT+range)-1. While enabled, the counter then drops by one per cycle, and it is readable at offset 0x08.
- R5: Writing 0x76 to offset 0x0C while enabled reloads the counter. Any other value written there leaves the counter's countdown undisturbed.
- R6: In direct mode, a cycle that starts with the counter at 0 makes rst_req high for exactly PULSE_CYC cycles, from the next cycle on. The counter reloads at the same time.
- R7: In warning mode, an expiry with no interrupt pending sets irq, and offset 0x10 reads 1. An expiry with irq still pending starts the rst_req pulse instead.
- R8: A read of offset 0x14 clears irq, after which offset 0x10 reads 0. The next expiry then raises irq again and does not reset.
- R9: Writes to undefined offsets change nothing, and reads from them return 0.
- R10: A valid restart in a cycle where the counter is 0 takes priority, so no expiry, no irq and no reset come from that cycle.
- R11: The range field is bits 3:0 of offset 0x04 and reads back. A new value applies only from the next reload.
- R12: While disabled, the counter stays 0 and restart writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Timeout warning interrupt (level) |
| rst_req | output | 1 | System reset request pulse |

## Verification
The assertions assume APB transfers that are well formed: penable is only high in the second cycle of a selected transfer, and paddr, pwrite and pwdata stay stable through the access phase. They also assume at most one transfer in flight. The bench's setup/access/idle tasks produce only such transfers, one at a time. It drives every input on the falling edge. To hit the restart-at-zero priority case exactly, it times the access phase from the counter value in its own model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_TOP  = 8'h04;
  localparam logic [7:0] OFS_CNT  = 8'h08;
  localparam logic [7:0] OFS_KICK = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_EOI  = 8'h14;
  localparam logic [7:0] OFS_ID   = 8'h18;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic       en;
    logic       irq_mode;
    logic [3:0] top;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 32,
  parameter logic [31:0] VERSION = 32'h3130332A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              irq,
  output wdt_cfg_t          cfg,
  output logic              arm,
  output logic              kick,
  output logic              eoi,
  output logic [31:0]       prdata
);
  logic acc, wr, rd;
  assign acc = psel & penable;
  assign wr  = acc & pwrite;
  assign rd  = acc & ~pwrite;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr && hit(paddr, OFS_CTRL)) begin
        cfg.en       <= cfg.en | pwdata[0];
        cfg.irq_mode <= pwdata[1];
      end
      if (wr && hit(paddr, OFS_TOP)) cfg.top <= pwdata[3:0];
    end
  end

  assign arm  = wr && hit(paddr, OFS_CTRL) && pwdata[0] && !cfg.en;
  assign kick = wr && hit(paddr, OFS_KICK) && (pwdata == KICK_KEY) && cfg.en;
  assign eoi  = rd && hit(paddr, OFS_EOI);

  always_comb begin
    prdata = '0;
    if (hit(paddr, OFS_CTRL))      prdata = {30'd0, cfg.irq_mode, cfg.en};
    else if (hit(paddr, OFS_TOP))  prdata = {28'd0, cfg.top};
    else if (hit(paddr, OFS_CNT))  prdata = 32'(cnt);
    else if (hit(paddr, OFS_STAT)) prdata = {31'd0, irq};
    else if (hit(paddr, OFS_ID))   prdata = VERSION;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32,
  parameter int BASE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       top,
  input  logic             arm,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] reload;
  assign reload = (CNT_W'(1) << (BASE_SHIFT + int'(top))) - CNT_W'(1);
  assign expire = en && (cnt == '0) && !kick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (arm || kick) begin
      cnt <= reload;
    end else if (en) begin
      cnt <= (cnt == '0) ? reload : cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_response.sv
module wdt_response #(
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_mode,
  input  logic eoi,
  output logic irq,
  output logic rst_req
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  logic [PW-1:0] pulse_q;
  logic fire;

  assign fire    = expire && (!irq_mode || irq);
  assign rst_req = pulse_q != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      pulse_q <= '0;
    end else begin
      irq <= (irq && !eoi) || (expire && irq_mode && !irq);
      if (fire)          pulse_q <= PW'(PULSE_CYC);
      else if (rst_req)  pulse_q <= pulse_q - PW'(1);
    end
  end
endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE_SHIFT = 16,
  parameter int PULSE_CYC = 8,
  parameter logic [31:0] VERSION = 32'h3130332A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq,
  output logic              rst_req
);
  localparam int CNT_W = BASE_SHIFT + 16;

  wdt_cfg_t         cfg;
  logic             arm, kick, eoi, expire, en_q;
  logic [CNT_W-1:0] cnt_q;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign en_q    = cfg.en;

  wdt_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt(cnt_q), .irq(irq), .cfg(cfg),
    .arm(arm), .kick(kick), .eoi(eoi), .prdata(prdata)
  );

  wdt_counter #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .top(cfg.top), .arm(arm),
    .kick(kick), .cnt(cnt_q), .expire(expire)
  );

  wdt_response #(.PULSE_CYC(PULSE_CYC)) u_resp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_mode(cfg.irq_mode),
    .eoi(eoi), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/apb_watchdog_chk.sv
module apb_watchdog_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              irq,
  input logic              rst_req,
  input logic              en,
  input logic [CNT_W-1:0]  cnt
);
  logic kick_w, eoi_w;
  assign kick_w = psel && penable && pwrite && (paddr == ADDR_W'(OFS_KICK)) && (pwdata == KICK_KEY) && en;
  assign eoi_w  = psel && penable && !pwrite && (paddr == ADDR_W'(OFS_EOI));

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> en);
  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> cnt == '0);
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0 && !kick_w) |=> cnt == $past(cnt) - CNT_W'(1));
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en && cnt == '0));
  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(en && cnt == '0));
  // R8
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_w && irq) |=> !irq);
  // R10
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_w && cnt == '0) |=> (!$rose(rst_req) && !$rose(irq)));
endmodule

bind apb_watchdog apb_watchdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .irq(irq), .rst_req(rst_req),
  .en(en_q), .cnt(cnt_q)
);

// File: tb/apb_watchdog_bench.sv
module apb_watchdog_bench;
  localparam int BS = 2;
  localparam int PULSE = 4;
  localparam logic [31:0] VER = 32'h3130332A;

  logic clk = 0, rst_n = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr, irq, rst_req;
  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit m_en, m_mode, m_irq;
  int m_top, m_pulse;
  longint m_cnt;

  always #4 clk = ~clk;

  apb_watchdog #(.BASE_SHIFT(BS), .PULSE_CYC(PULSE), .VERSION(VER)) u_apb_watchdog (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq), .rst_req(rst_req)
  );

  function automatic longint period(int t);
    return (longint'(1) << (BS + t)) - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_irq = 0; m_top = 0; m_pulse = 0; m_cnt = 0;
    end else begin
      bit wr, rd, kick, exp_now, fire, arm;
      wr = psel && penable && pwrite;
      rd = psel && penable && !pwrite;
      kick = wr && paddr == 8'h0C && pwdata == 32'h76 && m_en;
      arm = wr && paddr == 8'h00 && pwdata[0] && !m_en;
      exp_now = m_en && m_cnt == 0 && !kick;
      fire = exp_now && (!m_mode || m_irq);
      if (arm || kick) m_cnt = period(m_top);
      else if (m_en) m_cnt = (m_cnt == 0) ? period(m_top) : m_cnt - 1;
      if (fire) m_pulse = PULSE; else if (m_pulse > 0) m_pulse--;
      if (rd && paddr == 8'h14) m_irq = 0;
      else if (exp_now && m_mode && !m_irq) m_irq = 1;
      if (wr && paddr == 8'h00) begin m_en = m_en | pwdata[0]; m_mode = pwdata[1]; end
      if (wr && paddr == 8'h04) m_top = int'(pwdata[3:0]);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      vectors++;
      if (irq !== m_irq) begin errors++; $display("FAIL R7/R8 irq act=%0b exp=%0b", irq, m_irq); end
      if (rst_req !== (m_pulse != 0)) begin errors++; $display("FAIL R6 rst_req act=%0b exp=%0b", rst_req, m_pulse != 0); end
      if (pready !== 1'b1 || pslverr !== 1'b0) begin errors++; $display("FAIL R9 pready/pslverr act=%0b%0b exp=10", pready, pslverr); end
    end
    if (cycles > 20000 && !done) begin
      errors++; $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin errors++; $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp); end
  endtask

  function automatic longint model_rd(logic [7:0] a);
    case (a)
      8'h00: return {m_mode, m_en};
      8'h04: return m_top;
      8'h08: return m_cnt;
      8'h10: return m_irq;
      8'h18: return VER;
      default: return 0;
    endcase
  endfunction

  task automatic apb_wr(logic [7:0] a, logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 chk(tag, prdata, model_rd(a));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_sig(bit want_irq, bit want_rst);
    for (int i = 0; i < 200; i++) begin
      if ((want_irq && irq) || (want_rst && rst_req)) return;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    bit saw_rst;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);
    rd_chk("R1 ctrl", 8'h00); rd_chk("R1 cnt", 8'h08);
    chk("R1 cnt zero", m_cnt, 0);
    // R2 version, R9 undefined offset
    rd_chk("R2 version", 8'h18);
    chk("R2 model version", model_rd(8'h18), 32'h3130332A);
    apb_wr(8'h20, 32'hFFFF_FFFF);
    rd_chk("R9 undefined read", 8'h20);
    rd_chk("R9 ctrl untouched", 8'h00);
    // R12 restart while disabled
    apb_wr(8'h0C, 32'h76);
    rd_chk("R12 cnt stays 0", 8'h08);
    // R11 range readback, R4 enable load
    apb_wr(8'h04, 32'hFFFF_FFF2);
    rd_chk("R11 top readback", 8'h04);
    apb_wr(8'h00, 32'h1);
    rd_chk("R4 cnt after enable", 8'h08);
    rd_chk("R4 cnt decrements", 8'h08);
    // R5 wrong key ignored then right key reloads
    apb_wr(8'h0C, 32'h55);
    rd_chk("R5 wrong key", 8'h08);
    apb_wr(8'h0C, 32'h76);
    rd_chk("R5 key reload", 8'h08);
    // R3 enable sticky
    apb_wr(8'h00, 32'h0);
    rd_chk("R3 enable sticky", 8'h00);
    // R6 direct mode pulse length
    wait_sig(0, 1);
    chk("R6 reset seen", rst_req, 1);
    n = 0;
    repeat (10) begin if (rst_req) n++; @(negedge clk); end
    chk("R6 pulse length", n, PULSE);
    chk("R6 no irq in direct mode", irq, 0);
    // R7 warning mode
    apb_wr(8'h00, 32'h3);
    apb_wr(8'h0C, 32'h76);
    wait_sig(1, 1);
    chk("R7 irq first", irq, 1); chk("R7 no reset first", rst_req, 0);
    rd_chk("R7 status 1", 8'h10);
    // R8 EOI clears
    rd_chk("R8 eoi read", 8'h14);
    rd_chk("R8 status 0", 8'h10);
    saw_rst = 0;
    for (int i = 0; i < 200 && !irq; i++) begin if (rst_req) saw_rst = 1; @(negedge clk); end
    chk("R8 irq again", irq, 1); chk("R8 no reset", saw_rst, 0);
    wait_sig(0, 1);
    chk("R7 second expiry resets", rst_req, 1); chk("R7 irq still pending", irq, 1);
    // R10 restart in the zero cycle
    for (int i = 0; i < 200 && (rst_req || m_cnt != 1); i++) @(negedge clk);
    apb_wr(8'h0C, 32'h76);
    chk("R10 no reset", rst_req, 0);
    rd_chk("R10 reloaded", 8'h08);
    // R11 new range applies on next reload only
    apb_wr(8'h04, 32'h1);
    rd_chk("R11 cnt unchanged", 8'h08);
    apb_wr(8'h0C, 32'h76);
    chk("R11 new reload", m_cnt <= period(1), 1);
    rd_chk("R11 cnt new period", 8'h08);
    repeat (40) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule